// File: doc/BRIEF.md
# 5x5 Corner Non-Maximum Suppression Filter

This block thins the output of a corner detector that delivers one pixel per clock in raster order. Each pixel carries a candidate flag and an unsigned corner score. A flagged pixel survives only if no pixel in the 5x5 neighbourhood centred on it has a strictly higher score. Four line buffers, each `LINE_W` entries deep, hold the four earlier rows, and a 5x5 register window holds the current neighbourhood. A four-stage compare pipeline then decides on the centre pixel.

Each result belongs to the pixel two rows and two columns behind the newest input. The input may pause: a clock with `in_valid` low moves nothing in the window and produces no result. A small fill controller has three states. `ST_IDLE` is the state after reset. The first accepted pixel moves it to `ST_FILL`. Accepting stream pixel number 2·`LINE_W`+2 (counting from 0) moves it to `ST_STREAM`, and that pixel releases the first result. `ST_STREAM` is never left until reset.

The block does not clear its line buffers. Window positions outside the image are forced to score zero instead, using the centre's row and column. This has the same effect as clearing the buffers at each frame start, and it also isolates one frame from the next.

Top module: `corner_nms5`

## Requirements
- R1: After reset `out_valid` and `out_flag` are 0. No result appears until 2·`LINE_W`+3 pixels have been accepted; the first result belongs to row 0, column 0.
- R2: The result for centre pixel (r,c) appears on the fourth rising edge after the edge that accepts the pixel two rows and two columns later in the stream.
- R3: Each accepted pixel, once the window is filled, yields exactly one result in stream order. Clocks with `in_valid` low yield none and do not disturb later results.
- R4: A flagged centre whose score is at least every in-image neighbour's effective score gives `out_flag`=1 and `out_score` equal to its score.
- R5: A flagged centre with any in-image neighbour of strictly higher effective score gives `out_flag`=0 and `out_score`=0.
- R6: An unflagged neighbour counts with effective score 0, whatever its raw score.
- R7: A neighbour with a score equal to the centre's does not suppress the centre, so a flat plateau of flagged pixels is kept entirely.
- R8: Window positions whose row is outside 0..`FRAME_H`-1 or whose column is outside 0..`LINE_W`-1 count as score 0. Pixels of a neighbouring frame or of the wrapped-around line never suppress.
- R9: `in_sof` high on an accepted pixel places that pixel at row 0, column 0. Rows wrap after `FRAME_H`.
- R10: An unflagged centre always gives `out_flag`=0 and `out_score`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel present this clock |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_flag | input | 1 | Candidate corner flag |
| in_score | input | SCORE_W | Corner score |
| out_valid | output | 1 | Result present this clock |
| out_flag | output | 1 | Centre survives suppression |
| out_score | output | SCORE_W | Centre score when kept, else 0 |

## Verification
Once the window is filled, every accepted pixel completes the neighbourhood of the pixel two rows and two columns earlier in the stream. The result for that centre is due exactly four clocks after the accepting edge. The driver computes each expected result from a software model of the frame when it feeds the completing pixel, and stamps it with the accept cycle plus four. The monitor compares flag, score and arrival cycle against the head of the queue, so a stray, missing or mistimed result is caught even across input pauses.

// File: rtl/nms_pkg.sv
package nms_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2
    } fill_state_e;

    localparam int WIN_K    = 5;
    localparam int WIN_HALF = 2;
    localparam int LB_ROWS  = WIN_K - 1;

endpackage

// File: rtl/nms_raster_ctl.sv
module nms_raster_ctl
    import nms_pkg::*;
#(
    parameter int LINE_W  = 512,
    parameter int FRAME_H = 512,
    localparam int COL_W  = (LINE_W  > 1) ? $clog2(LINE_W)  : 1,
    localparam int ROW_W  = (FRAME_H > 1) ? $clog2(FRAME_H) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic [COL_W-1:0] acc_col,
    output logic [ROW_W-1:0] ctr_row,
    output logic [COL_W-1:0] ctr_col,
    output logic             win_valid
);
    localparam int FILL_N = WIN_HALF * LINE_W + WIN_HALF;
    localparam int CNT_W  = $clog2(FILL_N + 1);

    fill_state_e      state_q, state_d;
    logic [CNT_W-1:0] fill_cnt;
    logic [COL_W-1:0] pos_col;
    logic [ROW_W-1:0] pos_row;
    logic [ROW_W-1:0] acc_row;
    logic [COL_W-1:0] nxt_col, cen_col;
    logic [ROW_W-1:0] nxt_row, cen_row;
    logic             emit;
    int               t_c, t_r;

    // position of the pixel being accepted
    always_comb begin
        acc_col = in_sof ? '0 : pos_col;
        acc_row = in_sof ? '0 : pos_row;
    end

    // position of the following pixel
    always_comb begin
        if (acc_col == COL_W'(LINE_W - 1)) begin
            nxt_col = '0;
            nxt_row = (acc_row == ROW_W'(FRAME_H - 1)) ? '0 : acc_row + 1'b1;
        end else begin
            nxt_col = acc_col + 1'b1;
            nxt_row = acc_row;
        end
    end

    // centre lies two rows and two columns behind the accepted pixel
    always_comb begin
        t_c = int'(acc_col) - WIN_HALF;
        t_r = int'(acc_row) - WIN_HALF;
        if (t_c < 0) begin
            t_c = t_c + LINE_W;
            t_r = t_r - 1;
        end
        if (t_r < 0) t_r = t_r + FRAME_H;
        cen_col = COL_W'(t_c);
        cen_row = ROW_W'(t_r);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fill_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid && state_q != ST_STREAM)
                fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // next state and emit
    always_comb begin
        state_d = state_q;
        emit    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (in_valid && fill_cnt == CNT_W'(FILL_N)) begin
                    state_d = ST_STREAM;
                    emit    = 1'b1;
                end
            end
            ST_STREAM: begin
                emit = in_valid;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_col   <= '0;
            pos_row   <= '0;
            ctr_col   <= '0;
            ctr_row   <= '0;
            win_valid <= 1'b0;
        end else begin
            win_valid <= emit;
            if (in_valid) begin
                pos_col <= nxt_col;
                pos_row <= nxt_row;
                ctr_col <= cen_col;
                ctr_row <= cen_row;
            end
        end
    end

    // R9: position stays inside the frame
    p_pos_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pos_col) < LINE_W) && (int'(pos_row) < FRAME_H));

    // R9: frame start realigns the raster position
    p_sof_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (pos_col == COL_W'(1) && pos_row == '0));

    // R1: streaming state is sticky
    p_stream_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM) |=> (state_q == ST_STREAM));

    // R1: nothing leaves before the window has started filling
    p_no_early_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (state_q != ST_IDLE));

endmodule

// File: rtl/nms_line_store.sv
module nms_line_store
    import nms_pkg::*;
#(
    parameter int LINE_W  = 512,
    parameter int SCORE_W = 12,
    localparam int COL_W  = (LINE_W > 1) ? $clog2(LINE_W) : 1,
    localparam int EW     = SCORE_W + 1,
    localparam int NCELL  = WIN_K * WIN_K
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [COL_W-1:0]   addr,
    input  logic               new_flag,
    input  logic [SCORE_W-1:0] new_score,
    output logic [NCELL*EW-1:0] win_flat
);
    logic [EW-1:0] new_ent;
    logic [EW-1:0] lb_rd  [LB_ROWS];
    logic [EW-1:0] col_in [WIN_K];
    logic [EW-1:0] win    [WIN_K][WIN_K];

    assign new_ent = {new_flag, new_score};

    // chained line buffers: buffer k holds the row k+1 lines back
    for (genvar k = 0; k < LB_ROWS; k++) begin : g_line
        logic [EW-1:0] mem [LINE_W];
        logic [EW-1:0] wr_data;
        if (k == 0) begin : g_head
            assign wr_data = new_ent;
        end else begin : g_chain
            assign wr_data = lb_rd[k-1];
        end
        assign lb_rd[k] = mem[addr];
        always_ff @(posedge clk) begin
            if (accept) mem[addr] <= wr_data;
        end
    end

    // newest column entering the window, oldest row at index 0
    assign col_in[WIN_K-1] = new_ent;
    for (genvar k = 0; k < LB_ROWS; k++) begin : g_colin
        assign col_in[WIN_K-2-k] = lb_rd[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_K; i++)
                for (int j = 0; j < WIN_K; j++)
                    win[i][j] <= '0;
        end else if (accept) begin
            for (int i = 0; i < WIN_K; i++) begin
                for (int j = 0; j < WIN_K-1; j++)
                    win[i][j] <= win[i][j+1];
                win[i][WIN_K-1] <= col_in[i];
            end
        end
    end

    for (genvar i = 0; i < WIN_K; i++) begin : g_row
        for (genvar j = 0; j < WIN_K; j++) begin : g_col
            assign win_flat[(i*WIN_K+j)*EW +: EW] = win[i][j];
        end
    end

    // R3: a paused input leaves the window untouched
    p_hold_on_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(win_flat));

endmodule

// File: rtl/nms_decide.sv
module nms_decide
    import nms_pkg::*;
#(
    parameter int LINE_W  = 512,
    parameter int FRAME_H = 512,
    parameter int SCORE_W = 12,
    localparam int COL_W  = (LINE_W  > 1) ? $clog2(LINE_W)  : 1,
    localparam int ROW_W  = (FRAME_H > 1) ? $clog2(FRAME_H) : 1,
    localparam int EW     = SCORE_W + 1,
    localparam int NCELL  = WIN_K * WIN_K,
    localparam int CIDX   = WIN_HALF * WIN_K + WIN_HALF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_valid,
    input  logic [NCELL*EW-1:0] win_flat,
    input  logic [ROW_W-1:0]    ctr_row,
    input  logic [COL_W-1:0]    ctr_col,
    output logic                out_valid,
    output logic                out_flag,
    output logic [SCORE_W-1:0]  out_score
);
    logic [SCORE_W-1:0] mval [NCELL];

    // stage 1: effective scores
    logic [SCORE_W-1:0] s1_m [NCELL];
    logic               s1_valid, s1_cflag;
    // stage 2: per-neighbour comparisons
    logic [NCELL-1:0]   s2_ge;
    logic               s2_valid, s2_cflag;
    logic [SCORE_W-1:0] s2_cscore;
    // stage 3: per-row reduction
    logic [WIN_K-1:0]   s3_row;
    logic               s3_valid, s3_cflag;
    logic [SCORE_W-1:0] s3_cscore;

    for (genvar gi = 0; gi < WIN_K; gi++) begin : g_mr
        for (genvar gj = 0; gj < WIN_K; gj++) begin : g_mc
            localparam int N  = gi * WIN_K + gj;
            localparam int DR = gi - WIN_HALF;
            localparam int DC = gj - WIN_HALF;
            logic in_img, cell_flag;
            assign cell_flag = win_flat[N*EW + SCORE_W];
            assign in_img = (int'(ctr_row) + DR >= 0) && (int'(ctr_row) + DR < FRAME_H) &&
                            (int'(ctr_col) + DC >= 0) && (int'(ctr_col) + DC < LINE_W);
            assign mval[N] = (in_img && cell_flag) ? win_flat[N*EW +: SCORE_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NCELL; n++) s1_m[n] <= '0;
            s1_valid <= 1'b0;
            s1_cflag <= 1'b0;
        end else begin
            for (int n = 0; n < NCELL; n++) s1_m[n] <= mval[n];
            s1_valid <= win_valid;
            s1_cflag <= win_flat[CIDX*EW + SCORE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_ge     <= '0;
            s2_valid  <= 1'b0;
            s2_cflag  <= 1'b0;
            s2_cscore <= '0;
        end else begin
            for (int n = 0; n < NCELL; n++)
                s2_ge[n] <= (n == CIDX) ? 1'b1 : (s1_m[CIDX] >= s1_m[n]);
            s2_valid  <= s1_valid;
            s2_cflag  <= s1_cflag;
            s2_cscore <= s1_m[CIDX];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_row    <= '0;
            s3_valid  <= 1'b0;
            s3_cflag  <= 1'b0;
            s3_cscore <= '0;
        end else begin
            for (int i = 0; i < WIN_K; i++)
                s3_row[i] <= &s2_ge[i*WIN_K +: WIN_K];
            s3_valid  <= s2_valid;
            s3_cflag  <= s2_cflag;
            s3_cscore <= s2_cscore;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_flag  <= 1'b0;
            out_score <= '0;
        end else begin
            out_valid <= s3_valid;
            out_flag  <= s3_valid && s3_cflag && (&s3_row);
            out_score <= (s3_valid && s3_cflag && (&s3_row)) ? s3_cscore : '0;
        end
    end

    // R2: result leaves four clocks after the window was complete
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(win_valid, 4));

    // R5: a kept centre beat or tied every neighbour
    p_keep_needs_ge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_flag |-> (&$past(s2_ge, 2)));

    // R4: a kept centre reports its own score
    p_kept_score_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_flag |-> (out_score == $past(s1_m[CIDX], 3)));

    // R10: an unflagged centre never survives
    p_unflagged_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_cflag) |-> ##3 (!out_flag && out_score == '0));

endmodule

// File: rtl/corner_nms5.sv
module corner_nms5
    import nms_pkg::*;
#(
    parameter int LINE_W  = 512,
    parameter int FRAME_H = 512,
    parameter int SCORE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_flag,
    input  logic [SCORE_W-1:0] in_score,
    output logic               out_valid,
    output logic               out_flag,
    output logic [SCORE_W-1:0] out_score
);
    localparam int COL_W = (LINE_W  > 1) ? $clog2(LINE_W)  : 1;
    localparam int ROW_W = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;
    localparam int EW    = SCORE_W + 1;
    localparam int NCELL = WIN_K * WIN_K;

    logic [COL_W-1:0]    acc_col;
    logic [COL_W-1:0]    ctr_col;
    logic [ROW_W-1:0]    ctr_row;
    logic                win_valid;
    logic [NCELL*EW-1:0] win_flat;

    nms_raster_ctl #(
        .LINE_W (LINE_W),
        .FRAME_H(FRAME_H)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .acc_col  (acc_col),
        .ctr_row  (ctr_row),
        .ctr_col  (ctr_col),
        .win_valid(win_valid)
    );

    nms_line_store #(
        .LINE_W (LINE_W),
        .SCORE_W(SCORE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (in_valid),
        .addr     (acc_col),
        .new_flag (in_flag),
        .new_score(in_score),
        .win_flat (win_flat)
    );

    nms_decide #(
        .LINE_W (LINE_W),
        .FRAME_H(FRAME_H),
        .SCORE_W(SCORE_W)
    ) u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_valid(win_valid),
        .win_flat (win_flat),
        .ctr_row  (ctr_row),
        .ctr_col  (ctr_col),
        .out_valid(out_valid),
        .out_flag (out_flag),
        .out_score(out_score)
    );

endmodule

// File: tb/corner_nms5_tb_top.sv
module corner_nms5_tb_top;
    localparam int W  = 8;
    localparam int H  = 6;
    localparam int SW = 12;
    localparam int NF = 5;
    localparam int LAG = 2 * W + 2;

    typedef struct {
        int    flag;
        int    score;
        int    cyc;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic          in_flag = 1'b0;
    logic [SW-1:0] in_score = '0;
    logic          out_valid, out_flag;
    logic [SW-1:0] out_score;

    int   fl_a [NF][H][W];
    int   sc_a [NF][H][W];
    exp_t q [$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    corner_nms5 #(.LINE_W(W), .FRAME_H(H), .SCORE_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_flag(in_flag), .in_score(in_score),
        .out_valid(out_valid), .out_flag(out_flag), .out_score(out_score)
    );

    function automatic int rnd8();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]);
    endfunction

    function automatic exp_t model(int s);
        exp_t e;
        int f, r, c, cs, nv;
        bit kept, tie, hid;
        f = s / (W * H);
        r = (s / W) % H;
        c = s % W;
        cs = sc_a[f][r][c];
        kept = (fl_a[f][r][c] != 0);
        tie = 0;
        hid = 0;
        for (int dr = -2; dr <= 2; dr++) begin
            for (int dc = -2; dc <= 2; dc++) begin
                if ((dr != 0 || dc != 0) && r + dr >= 0 && r + dr < H && c + dc >= 0 && c + dc < W) begin
                    nv = fl_a[f][r+dr][c+dc] ? sc_a[f][r+dr][c+dc] : 0;
                    if (nv > cs) kept = 0;
                    if (nv == cs) tie = 1;
                    if (!fl_a[f][r+dr][c+dc] && sc_a[f][r+dr][c+dc] > cs) hid = 1;
                end
            end
        end
        e.flag  = kept ? 1 : 0;
        e.score = kept ? cs : 0;
        if (fl_a[f][r][c] == 0)                       e.tag = "R10";
        else if (f > 0 && r == 0 && c == 0)           e.tag = "R9";
        else if (tie)                                 e.tag = "R7";
        else if (hid)                                 e.tag = "R6";
        else if (r < 2 || r > H - 3 || c < 2 || c > W - 3) e.tag = "R8";
        else if (kept)                                e.tag = "R4";
        else                                          e.tag = "R5";
        return e;
    endfunction

    task automatic drive_px(int f, int r, int c);
        exp_t e;
        int s;
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (r == 0 && c == 0);
        in_flag  = fl_a[f][r][c][0];
        in_score = SW'(sc_a[f][r][c]);
        s = f * W * H + r * W + c;
        if (s >= LAG) begin
            e = model(s - LAG);
            e.cyc = cyc + 5;
            q.push_back(e);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b1;
            in_flag  = 1'b1;
            in_score = SW'(4000);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R3 unexpected result: got flag=%0d score=%0d expected none",
                         out_flag, out_score);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (cyc != e.cyc) begin
                    n_fail++;
                    $display("FAIL R2 arrival cycle: got %0d expected %0d", cyc, e.cyc);
                end
                n_chk++;
                if (int'(out_flag) != e.flag || int'(out_score) != e.score) begin
                    n_fail++;
                    $display("FAIL %s result: got flag=%0d score=%0d expected flag=%0d score=%0d",
                             e.tag, out_flag, out_score, e.flag, e.score);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: got hang expected completion");
        finish_run();
    end

    initial begin
        // frame 0: pseudo-random scores and flags
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                sc_a[0][r][c] = rnd8();
                fl_a[0][r][c] = (rnd8() < 170) ? 1 : 0;
            end
        // frame 1: flat plateau, all flagged (R7)
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                sc_a[1][r][c] = 50;
                fl_a[1][r][c] = 1;
            end
        // frame 2: single peak, hidden high unflagged neighbours (R6)
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                sc_a[2][r][c] = 10 + r + c;
                fl_a[2][r][c] = 1;
            end
        sc_a[2][3][4] = 200;
        sc_a[2][2][3] = 250; fl_a[2][2][3] = 0;
        sc_a[2][4][6] = 300; fl_a[2][4][6] = 0;
        sc_a[2][0][7] = 400;
        // frame 3: random, fed with pauses (R3)
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                sc_a[3][r][c] = rnd8() + 1000;
                fl_a[3][r][c] = (rnd8() < 200) ? 1 : 0;
            end
        // frame 4: empty flush frame
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                sc_a[4][r][c] = 3000;
                fl_a[4][r][c] = 0;
            end

        // R1: reset state
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: got valid=%0d flag=%0d expected 0 0", out_valid, out_flag);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        for (int f = 0; f < NF; f++)
            for (int r = 0; r < H; r++)
                for (int c = 0; c < W; c++) begin
                    drive_px(f, r, c);
                    if (f == 3 && (c % 3) == 1) idle(1 + (r % 3));
                end
        idle(10);

        // R3: every expected result has arrived
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R3 missing results: got %0d pending expected 0", q.size());
        end
        finish_run();
    end

endmodule